// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

A single-port static memory with 32-bit words, a small parameterized depth and a synchronous front end. On each rising clock edge the block samples the address, the write data, three chip-select inputs, two address-load strobes (one meant for a processor, one for a memory controller), a burst-advance input and the write controls. A load strobe starts a new access sequence at the presented address. From then on, a two-bit counter produces the remaining three word addresses of a four-word group. The counter walks the group either linearly or in interleaved (XOR) order, as chosen by a mode input.

Reads go through two register stages, the access register and the output register. A burst therefore delivers its first word in the third clock counted from the load clock, and each further word one clock later. Writes take a per-byte mask from four lane strobes qualified by a master gate, and a global write input overrides the mask so that the whole word is written. Output enable and a sleep input act combinationally on the data output drivers. Sleep also makes every clock edge ignore the synchronous inputs.

Top module: `sbsram_core`

## Requirements
- R1: A load by the controller strobe (`strobe_mc_n_i` low) captures `addr_i` as the burst base. The block is selected only when `sel_pipe_n_i` is low, `sel_hi_i` is high and `sel_lo_n_i` is low. A load with any of the three inactive makes no access and leaves the block deselected, so `rdata_o` stays high impedance.
- R2: The processor strobe (`strobe_cpu_n_i` low) loads only if `sel_pipe_n_i` is low in the same cycle. Otherwise it is ignored and any running burst continues. The controller strobe loads whatever `sel_pipe_n_i` is, and it wins when both strobes are low.
- R3: While selected and with no load, each edge with `adv_n_i` low steps the two-bit burst count by one, wrapping 3 to 0. With `adv_n_i` high the count holds and the same word is accessed again.
- R4: The accessed word keeps the upper address bits of the base. With `order_lin_i`=1 its low two bits are (base[1:0] + count) mod 4. With `order_lin_i`=0 they are base[1:0] XOR count. A load resets the count to 0.
- R5: With `lane_wr_gate_n_i` low, bit g of `lane_wr_n_i` low writes data bits [8g+7:8g] and leaves the other lanes unchanged. With the gate high the lane strobes have no effect and the access is a read.
- R6: `wr_all_n_i` low writes all four lanes, whatever the gate and the lane strobes are.
- R7: The read data of an access accepted at edge k drives `rdata_o` from just after edge k+1. A burst advancing every clock yields one new word per clock.
- R8: `oe_n_i` high forces `rdata_o` to high impedance at once, without waiting for a clock edge.
- R9: While `sleep_i` is high, edges perform no access and leave the burst base, count and selection unchanged, and `rdata_o` is high impedance. After sleep ends, a running burst resumes from where it stood.
- R10: In the cycle after an edge that accepted a write access, `rdata_o` is high impedance.
- R11: After reset `rdata_o` is high impedance and the block is deselected until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sleep_i | input | 1 | Sleep: ignore edges, tri-state the output |
| oe_n_i | input | 1 | Active-low output enable, combinational |
| sel_pipe_n_i | input | 1 | Active-low select, also qualifies the processor strobe |
| sel_hi_i | input | 1 | Active-high depth-expansion select |
| sel_lo_n_i | input | 1 | Active-low depth-expansion select |
| strobe_cpu_n_i | input | 1 | Processor address-load strobe, active low |
| strobe_mc_n_i | input | 1 | Controller address-load strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| lane_wr_n_i | input | 4 | Per-byte write strobes, active low |
| lane_wr_gate_n_i | input | 1 | Master gate for the byte strobes, active low |
| wr_all_n_i | input | 1 | Global write of all lanes, active low |
| order_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr_i | input | AW | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, high impedance when not driving |

## Verification
The hardest situation to reach from the ports is a burst that the processor strobe should leave alone. This happens when that strobe arrives with the pipelining select inactive while a burst is running, possibly in the middle of an interleaved wrap or just after a sleep interval. Directed sequences first start a burst and then present an ignored strobe with a new address, or hold sleep over several edges that carry load and write attempts. The random phase mixes independent strobes, selects, advance and sleep with per-cycle probabilities chosen so that long bursts, collisions of both strobes and gated byte writes all occur often. A bench model of the array and the burst state predicts every output word.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

   localparam int unsigned LANE_W = 8;

   // Low two word-address bits of burst step `step` starting from `start`.
   function automatic logic [1:0] burst_low(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       linear);
      logic [1:0] sum;
      sum = start + step;
      return linear ? sum : (start ^ step);
   endfunction

endpackage

// File: rtl/sbsram_seq.sv
`timescale 1ns/1ps
module sbsram_seq
   import sbsram_pkg::*;
#(
   parameter int unsigned AW    = 6,
   parameter int unsigned LANES = 4,
   localparam int unsigned DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_i,
   input  logic             sel_pipe_n_i,
   input  logic             sel_hi_i,
   input  logic             sel_lo_n_i,
   input  logic             strobe_cpu_n_i,
   input  logic             strobe_mc_n_i,
   input  logic             adv_n_i,
   input  logic [LANES-1:0] lane_wr_n_i,
   input  logic             lane_wr_gate_n_i,
   input  logic             wr_all_n_i,
   input  logic             order_lin_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   output logic             acc_rd_o,
   output logic             acc_wr_o,
   output logic [AW-1:0]    acc_addr_o,
   output logic [LANES-1:0] acc_lanes_o,
   output logic [DW-1:0]    acc_wdata_o
);

   if (AW < 3) begin : g_bad_aw
      $error("sbsram_seq: AW must be at least 3");
   end

   logic [AW-1:0]    base_q;
   logic [1:0]       cnt_q, cnt_nxt;
   logic             sel_q;
   logic             chip_on, load, go, wr_req;
   logic [AW-1:0]    tgt;
   logic [LANES-1:0] lanes;

   assign chip_on = !sel_pipe_n_i && sel_hi_i && !sel_lo_n_i;
   // controller strobe always loads; processor strobe needs the pipelining select
   assign load    = !strobe_mc_n_i || (!strobe_cpu_n_i && !sel_pipe_n_i);

   always_comb begin
      if (load)                    cnt_nxt = 2'd0;
      else if (sel_q && !adv_n_i)  cnt_nxt = cnt_q + 2'd1;
      else                         cnt_nxt = cnt_q;
   end

   assign go  = load ? chip_on : sel_q;
   assign tgt = load ? addr_i
                     : {base_q[AW-1:2], burst_low(base_q[1:0], cnt_nxt, order_lin_i)};

   always_comb begin
      if (!wr_all_n_i)            lanes = '1;
      else if (!lane_wr_gate_n_i) lanes = ~lane_wr_n_i;
      else                        lanes = '0;
   end
   assign wr_req = |lanes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         cnt_q    <= '0;
         sel_q    <= 1'b0;
         acc_rd_o <= 1'b0;
         acc_wr_o <= 1'b0;
      end else if (sleep_i) begin
         acc_rd_o <= 1'b0;
         acc_wr_o <= 1'b0;
      end else begin
         if (load) begin
            base_q <= addr_i;
            sel_q  <= chip_on;
         end
         cnt_q    <= cnt_nxt;
         acc_rd_o <= go && !wr_req;
         acc_wr_o <= go && wr_req;
      end
   end

   always_ff @(posedge clk) begin
      if (!sleep_i) begin
         acc_addr_o  <= tgt;
         acc_lanes_o <= lanes;
         acc_wdata_o <= wdata_i;
      end
   end

   a_r1_load_access: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !strobe_mc_n_i && chip_on) |=>
         ((acc_rd_o || acc_wr_o) && acc_addr_o == $past(addr_i)));

   a_r2_cpu_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && strobe_mc_n_i && sel_pipe_n_i) |=>
         ($stable(base_q) && $stable(sel_q)));

   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !load && sel_q && !adv_n_i) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

   a_r9_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> (!acc_rd_o && !acc_wr_o && $stable(cnt_q) && $stable(base_q)));

   a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({acc_rd_o, acc_wr_o}));

endmodule

// File: rtl/sbsram_store.sv
`timescale 1ns/1ps
module sbsram_store
   import sbsram_pkg::*;
#(
   parameter int unsigned AW    = 6,
   parameter int unsigned LANES = 4,
   localparam int unsigned DW    = LANES * LANE_W,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_rd_i,
   input  logic             acc_wr_i,
   input  logic [AW-1:0]    acc_addr_i,
   input  logic [LANES-1:0] acc_lanes_i,
   input  logic [DW-1:0]    acc_wdata_i,
   output logic [DW-1:0]    rd_data_o,
   output logic             rd_valid_o
);

   if (DEPTH > 4096) begin : g_bad_depth
      $error("sbsram_store: depth too large for this core");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (acc_wr_i && acc_lanes_i[g])
            cells[acc_addr_i] <= acc_wdata_i[g*LANE_W +: LANE_W];
         if (acc_rd_i)
            lane_q <= cells[acc_addr_i];
      end
      assign rd_data_o[g*LANE_W +: LANE_W] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid_o <= 1'b0;
      else        rd_valid_o <= acc_rd_i;
   end

   a_r7_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rd_i |=> rd_valid_o);

endmodule

// File: rtl/sbsram_core.sv
`timescale 1ns/1ps
module sbsram_core
   import sbsram_pkg::*;
#(
   parameter int unsigned AW    = 6,
   parameter int unsigned LANES = 4,
   localparam int unsigned DW   = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_i,
   input  logic             oe_n_i,
   input  logic             sel_pipe_n_i,
   input  logic             sel_hi_i,
   input  logic             sel_lo_n_i,
   input  logic             strobe_cpu_n_i,
   input  logic             strobe_mc_n_i,
   input  logic             adv_n_i,
   input  logic [LANES-1:0] lane_wr_n_i,
   input  logic             lane_wr_gate_n_i,
   input  logic             wr_all_n_i,
   input  logic             order_lin_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o
);

   if (LANES != 4) begin : g_bad_lanes
      $error("sbsram_core: four byte lanes expected");
   end

   logic             acc_rd, acc_wr;
   logic [AW-1:0]    acc_addr;
   logic [LANES-1:0] acc_lanes;
   logic [DW-1:0]    acc_wdata, rd_data;
   logic             rd_valid, hiz;

   sbsram_seq #(.AW(AW), .LANES(LANES)) u_seq (
      .clk, .rst_n, .sleep_i,
      .sel_pipe_n_i, .sel_hi_i, .sel_lo_n_i,
      .strobe_cpu_n_i, .strobe_mc_n_i, .adv_n_i,
      .lane_wr_n_i, .lane_wr_gate_n_i, .wr_all_n_i,
      .order_lin_i, .addr_i, .wdata_i,
      .acc_rd_o(acc_rd), .acc_wr_o(acc_wr), .acc_addr_o(acc_addr),
      .acc_lanes_o(acc_lanes), .acc_wdata_o(acc_wdata)
   );

   sbsram_store #(.AW(AW), .LANES(LANES)) u_store (
      .clk, .rst_n,
      .acc_rd_i(acc_rd), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
      .acc_lanes_i(acc_lanes), .acc_wdata_i(acc_wdata),
      .rd_data_o(rd_data), .rd_valid_o(rd_valid)
   );

   // drivers off: output disabled, asleep, write in flight, or nothing read
   assign hiz     = oe_n_i || sleep_i || acc_wr || !rd_valid;
   assign rdata_o = hiz ? {DW{1'bz}} : rd_data;

endmodule

// File: tb/sbsram_core_tb.sv
`timescale 1ns/1ps
module sbsram_core_tb;
   localparam int AW = 6;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep, oe_n, cep_n, ce_hi, ce_lo_n, sp_n, sc_n, adv_n;
   logic [3:0] bw_n;
   logic bwe_n, gw_n, lin;
   logic [AW-1:0] addr;
   logic [31:0] wdata;
   wire  [31:0] rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // bench model
   logic [31:0]   m_mem [DEPTH];
   logic [AW-1:0] m_base, m_acc_addr;
   logic [1:0]    m_cnt;
   logic          m_sel, m_acc_rd, m_acc_wr, m_outv;
   logic [3:0]    m_lanes;
   logic [31:0]   m_wdata, m_out;

   always #10 clk = ~clk;

   sbsram_core #(.AW(AW), .LANES(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .oe_n_i(oe_n),
      .sel_pipe_n_i(cep_n), .sel_hi_i(ce_hi), .sel_lo_n_i(ce_lo_n),
      .strobe_cpu_n_i(sp_n), .strobe_mc_n_i(sc_n), .adv_n_i(adv_n),
      .lane_wr_n_i(bw_n), .lane_wr_gate_n_i(bwe_n), .wr_all_n_i(gw_n),
      .order_lin_i(lin), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
   );

   function automatic logic [31:0] pat(input int i);
      return 32'hA5000000 ^ (i * 32'h01030507);
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic idle();
      sleep = 0; oe_n = 0; cep_n = 0; ce_hi = 1; ce_lo_n = 0;
      sp_n = 1; sc_n = 1; adv_n = 1; bw_n = 4'hF; bwe_n = 1; gw_n = 1;
   endtask

   task automatic model_reset();
      m_sel = 0; m_cnt = 0; m_base = '0; m_acc_rd = 0; m_acc_wr = 0; m_outv = 0;
   endtask

   task automatic model_edge();
      logic en, ld, v, wr;
      logic [1:0] lo;
      logic [AW-1:0] a;
      logic [3:0] ln;
      if (m_acc_wr)
         for (int l = 0; l < 4; l++)
            if (m_lanes[l]) m_mem[m_acc_addr][l*8 +: 8] = m_wdata[l*8 +: 8];
      m_outv = m_acc_rd;
      if (m_acc_rd) m_out = m_mem[m_acc_addr];
      if (sleep) begin
         m_acc_rd = 0; m_acc_wr = 0;
         return;
      end
      en = !cep_n && ce_hi && !ce_lo_n;
      ld = !sc_n || (!sp_n && !cep_n);
      a = addr;
      if (ld) begin
         m_base = addr; m_cnt = 0; m_sel = en; v = en;
      end else if (m_sel) begin
         if (!adv_n) m_cnt = m_cnt + 2'd1;
         lo = lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
         a = {m_base[AW-1:2], lo};
         v = 1;
      end else v = 0;
      ln = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
      wr = v && (ln != 4'h0);
      m_acc_wr = wr; m_acc_rd = v && !wr;
      m_acc_addr = a; m_lanes = ln; m_wdata = wdata;
   endtask

   task automatic check(input string tag);
      logic [31:0] exp;
      exp = (oe_n || sleep || m_acc_wr || !m_outv) ? 32'hzzzzzzzz : m_out;
      n_cmp++;
      if (rdata !== exp) begin
         n_bad++;
         $display("FAIL %s: rdata=%h expected=%h at %0t", tag, rdata, exp, $time);
      end
   endtask

   task automatic cyc(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag);
   endtask

   task automatic load_mc(input logic [AW-1:0] a);
      idle(); sc_n = 0; addr = a;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle(); lin = 1; addr = '0; wdata = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      check("R11 reset output");
      idle(); cyc("R11 idle after reset");

      // fill every word with global writes
      for (int i = 0; i < DEPTH; i++) begin
         load_mc(AW'(i)); gw_n = 0; wdata = pat(i);
         cyc("R6 fill write");
      end
      idle(); cyc("R10 after write");

      // R7 + R4 linear burst from a mid-group start
      load_mc(6'd10); lin = 1; cyc("R7 load");
      idle(); adv_n = 0;
      for (int k = 0; k < 5; k++) cyc("R4 linear burst");
      // R3 hold
      adv_n = 1; cyc("R3 hold"); cyc("R3 hold");

      // R4 interleaved burst from base 14
      load_mc(6'd14); lin = 0; cyc("R7 load");
      idle(); adv_n = 0;
      for (int k = 0; k < 5; k++) cyc("R4 interleave burst");

      // R8 asynchronous output enable
      oe_n = 1; #1 check("R8 oe async off");
      oe_n = 0; #1 check("R8 oe async on");

      // R2 ignored processor strobe during running burst
      idle(); sp_n = 0; cep_n = 1; addr = 6'd50; adv_n = 0;
      cyc("R2 cpu ignored"); idle(); cyc("R2 burst kept"); cyc("R2 burst kept");
      // R2 processor strobe honoured
      idle(); sp_n = 0; addr = 6'd33; cyc("R2 cpu load");
      idle(); adv_n = 0; cyc("R2 cpu data"); cyc("R2 cpu data");
      // R2 controller strobe wins even with pipelining select off -> deselect
      idle(); sc_n = 0; sp_n = 0; cep_n = 1; addr = 6'd5; cyc("R2 mc load");
      idle(); cyc("R1 deselected"); cyc("R1 deselected");
      // R1 each depth select alone
      load_mc(6'd7); ce_hi = 0; cyc("R1 sel_hi off"); idle(); cyc("R1 deselected");
      load_mc(6'd7); ce_lo_n = 1; cyc("R1 sel_lo off"); idle(); cyc("R1 deselected");

      // R5 byte lanes
      load_mc(6'd20); bwe_n = 0; bw_n = 4'b1010; wdata = 32'h11223344; cyc("R5 lane write");
      load_mc(6'd21); bwe_n = 1; bw_n = 4'b0000; wdata = 32'hDEADBEEF; cyc("R5 gate off read");
      load_mc(6'd22); gw_n = 0; bwe_n = 1; bw_n = 4'hF; wdata = 32'h0BADF00D; cyc("R6 global write");
      load_mc(6'd20); cyc("R10 read after write");
      idle(); adv_n = 0; lin = 1;
      cyc("R5 lane readback"); cyc("R5 gate readback"); cyc("R6 global readback");

      // R9 sleep over load and write attempts
      load_mc(6'd40); cyc("R9 pre load");
      idle(); adv_n = 0; sleep = 1; sc_n = 0; gw_n = 0; addr = 6'd41; wdata = 32'hFFFF0000;
      #1 check("R9 sleep async");
      cyc("R9 sleep"); cyc("R9 sleep"); cyc("R9 sleep");
      idle(); adv_n = 0; cyc("R9 resume"); cyc("R9 resume"); cyc("R9 resume");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         if (n % 40 == 0) lin = 1'($urandom);
         sc_n    = ($urandom % 100) >= 18;
         sp_n    = ($urandom % 100) >= 15;
         cep_n   = ($urandom % 100) >= 85;
         ce_hi   = ($urandom % 100) < 92;
         ce_lo_n = ($urandom % 100) >= 92;
         adv_n   = ($urandom % 100) >= 65;
         gw_n    = ($urandom % 100) >= 12;
         bwe_n   = ($urandom % 100) >= 25;
         bw_n    = 4'($urandom);
         oe_n    = ($urandom % 100) < 8;
         sleep   = ($urandom % 100) < 4;
         addr    = AW'($urandom);
         wdata   = $urandom;
         cyc("R7 random");
      end

      done = 1;
      summary();
      $finish;
   end
endmodule